// File: doc/BRIEF.md
# Two-Wire Bus Condition and Reset Detector

This block is the oversampled receive front end of a two-wire serial slave. It samples the raw clock and data lines on a fast system clock, resynchronises them and removes short glitches. It then hands the protocol engine clean one-cycle strobes for bus start, bus stop, clock rising edges (when data is latched) and clock falling edges (when the slave may change its output). The filtered line levels are also brought out, so the engine can shift in data bits at the rising strobe.

The block also watches for the bus recovery pattern. That pattern is a start, then exactly nine clock pulses with the data line released high on each of them, then a second start. When it completes, the block sends a one-cycle reset strobe. The protocol engine uses that strobe to return to its power-on state: address counter cleared, data line released, and any acknowledge or data transfer abandoned.

The glitch filter's hold time is derived from the system clock frequency and a suppression time in nanoseconds. With the defaults (50 MHz, 100 ns), a filtered level moves only after the resynchronised input has differed from it for 5 consecutive system clocks.

Top module: `twi_cond_frontend`

## Requirements
- R1: A falling edge of filtered SDA while filtered SCL is high gives exactly one `start_pulse`, one system clock wide.
- R2: A rising edge of filtered SDA while filtered SCL is high gives exactly one `stop_pulse`, one system clock wide.
- R3: SDA changes made while SCL is low produce neither `start_pulse` nor `stop_pulse`.
- R4: Each filtered SCL rising edge gives one `scl_rise_pulse` and each filtered SCL falling edge gives one `scl_fall_pulse`. Neither pulse occurs in the same cycle as a start or stop.
- R5: After the two-flop synchroniser, a line value that differs from the filtered level for fewer than HOLD consecutive clocks is ignored. A value that differs for HOLD consecutive clocks is adopted. HOLD = ceil(SYS_CLK_HZ × SUPPRESS_NS / 1e9), which is 5 by default.
- R6: An event strobe is high on the (HOLD+3)-th rising system clock edge, counting from the edge that first samples the changed pin.
- R7: During and right after reset, `scl_level` and `sda_level` are 1 and every strobe is 0.
- R8: A start, then nine complete SCL pulses with SDA high at every rising edge, then a start gives one `bus_reset_pulse`. That pulse is one clock wide, in the cycle right after the second `start_pulse`.
- R9: The reset pattern is dropped with no `bus_reset_pulse` if SDA is low at any of the nine rising SCL edges, or if a stop arrives before the second start.
- R10: The pulse count must be exactly nine. Eight pulses followed by a start, or ten pulses followed by a start, give no `bus_reset_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line |
| scl_level | output | 1 | Filtered SCL level |
| sda_level | output | 1 | Filtered SDA level |
| start_pulse | output | 1 | One-cycle start strobe |
| stop_pulse | output | 1 | One-cycle stop strobe |
| scl_rise_pulse | output | 1 | One-cycle strobe on filtered SCL rising |
| scl_fall_pulse | output | 1 | One-cycle strobe on filtered SCL falling |
| bus_reset_pulse | output | 1 | One-cycle bus recovery reset strobe |

## Verification
The assertions check several things on every cycle:
- a filtered level only moves to a value the synchroniser has just delivered, and the filter counter stays in range;
- start and stop occur only with SCL high, and never together with an SCL edge strobe;
- the recovery counter never passes nine;
- every reset strobe is one cycle wide and follows a start strobe.

Only the bench scenarios can show the rest: the exact latency in clocks, the boundary between a glitch that is one clock too short and one that just passes, that data changes under a low clock are ignored, and that the recovery pattern is accepted at exactly nine pulses but dropped at eight, at ten, on a low data bit, or on a stop.

// File: rtl/twi_fe_pkg.sv
package twi_fe_pkg;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_COUNT = 2'd1,
    RS_ARMED = 2'd2
  } rst_state_e;

  // Number of system clocks covering a suppression time, rounded up, at least 1.
  function automatic int cycles_for_ns(longint hz, longint ns);
    longint prod;
    longint cyc;
    prod = hz * ns;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc < 1) cyc = 1;
    return int'(cyc);
  endfunction

  // Bus condition classifiers on previous and current filtered levels.
  function automatic logic is_start(logic p_scl, logic p_sda, logic c_scl, logic c_sda);
    return p_scl & c_scl & p_sda & ~c_sda;
  endfunction

  function automatic logic is_stop(logic p_scl, logic p_sda, logic c_scl, logic c_sda);
    return p_scl & c_scl & ~p_sda & c_sda;
  endfunction

  function automatic logic is_rise(logic p_scl, logic c_scl);
    return ~p_scl & c_scl;
  endfunction

  function automatic logic is_fall(logic p_scl, logic c_scl);
    return p_scl & ~c_scl;
  endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int   STAGES     = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{IDLE_LEVEL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int   HOLD_CYCLES = 5,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] run_cnt;
  logic          differ;

  assign differ = (din != dout);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      dout    <= IDLE_LEVEL;
    end else if (!differ) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      run_cnt <= '0;
      dout    <= din;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R5: the filtered level only adopts the value the synchroniser just delivered
  assert_level_from_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> (dout == $past(din)));

  // R5: the run counter never reaches the hold limit
  assert_run_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LAST);
endmodule

// File: rtl/twi_cond_decode.sv
module twi_cond_decode
  import twi_fe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic prev_scl, prev_sda;
  logic start_w, stop_w, rise_w, fall_w;

  assign start_w = is_start(prev_scl, prev_sda, scl_f, sda_f);
  assign stop_w  = is_stop (prev_scl, prev_sda, scl_f, sda_f);
  assign rise_w  = is_rise (prev_scl, scl_f);
  assign fall_w  = is_fall (prev_scl, scl_f);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_scl <= 1'b1;
      prev_sda <= 1'b1;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
      rise_o   <= 1'b0;
      fall_o   <= 1'b0;
    end else begin
      prev_scl <= scl_f;
      prev_sda <= sda_f;
      start_o  <= start_w;
      stop_o   <= stop_w;
      rise_o   <= rise_w;
      fall_o   <= fall_w;
    end
  end

  // R1: a start strobe never repeats in the next cycle
  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R2: a stop strobe never repeats in the next cycle
  assert_stop_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);
endmodule

// File: rtl/twi_reset_seq.sv
module twi_reset_seq
  import twi_fe_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic sda_f,
  output logic bus_rst_o
);
  localparam int PW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] FULL = PW'(PULSES);

  rst_state_e     state;
  logic [PW-1:0]  pulse_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RS_IDLE;
      pulse_cnt <= '0;
      bus_rst_o <= 1'b0;
    end else begin
      bus_rst_o <= 1'b0;
      unique case (state)
        RS_IDLE: begin
          if (start_i) begin
            state     <= RS_COUNT;
            pulse_cnt <= '0;
          end
        end
        RS_COUNT: begin
          if (start_i) begin
            pulse_cnt <= '0;
          end else if (stop_i) begin
            state <= RS_IDLE;
          end else if (rise_i) begin
            if (!sda_f || pulse_cnt == FULL) state <= RS_IDLE;
            else                             pulse_cnt <= pulse_cnt + 1'b1;
          end else if (fall_i && pulse_cnt == FULL) begin
            state <= RS_ARMED;
          end
        end
        RS_ARMED: begin
          if (start_i) begin
            bus_rst_o <= 1'b1;
            state     <= RS_IDLE;
            pulse_cnt <= '0;
          end else if (stop_i || fall_i) begin
            state <= RS_IDLE;
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  // R10: the pulse counter never passes the required count
  assert_pulse_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= FULL);

  // R8: arming only happens once the full count is reached
  assert_armed_after_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_ARMED && $past(state) == RS_COUNT) |-> ($past(pulse_cnt) == FULL));
endmodule

// File: rtl/twi_cond_frontend.sv
module twi_cond_frontend
  import twi_fe_pkg::*;
#(
  parameter longint SYS_CLK_HZ  = 50_000_000,
  parameter longint SUPPRESS_NS = 100,
  parameter int     SYNC_STAGES = 2,
  parameter int     RST_PULSES  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_level,
  output logic sda_level,
  output logic start_pulse,
  output logic stop_pulse,
  output logic scl_rise_pulse,
  output logic scl_fall_pulse,
  output logic bus_reset_pulse
);
  localparam int HOLD  = cycles_for_ns(SYS_CLK_HZ, SUPPRESS_NS);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] sync_lines;
  logic [LINES-1:0] filt_lines;

  // index 1 = SCL, index 0 = SDA
  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    twi_sync #(
      .STAGES     (SYNC_STAGES),
      .IDLE_LEVEL (1'b1)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_lines[g]),
      .dout  (sync_lines[g])
    );

    twi_glitch_filter #(
      .HOLD_CYCLES (HOLD),
      .IDLE_LEVEL  (1'b1)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sync_lines[g]),
      .dout  (filt_lines[g])
    );
  end

  assign scl_level = filt_lines[1];
  assign sda_level = filt_lines[0];

  twi_cond_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_level),
    .sda_f   (sda_level),
    .start_o (start_pulse),
    .stop_o  (stop_pulse),
    .rise_o  (scl_rise_pulse),
    .fall_o  (scl_fall_pulse)
  );

  twi_reset_seq #(
    .PULSES (RST_PULSES)
  ) u_rst_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_pulse),
    .stop_i    (stop_pulse),
    .rise_i    (scl_rise_pulse),
    .fall_i    (scl_fall_pulse),
    .sda_f     (sda_level),
    .bus_rst_o (bus_reset_pulse)
  );

  // R1: a start is only reported while the filtered clock is high
  assert_start_scl_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> scl_level);

  // R2: a stop is only reported while the filtered clock is high
  assert_stop_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> scl_level);

  // R4: bus conditions never share a cycle with a clock edge strobe
  assert_cond_not_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || stop_pulse) |-> !(scl_rise_pulse || scl_fall_pulse));

  // R4: rising and falling strobes are mutually exclusive
  assert_edges_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise_pulse, scl_fall_pulse}));

  // R8: a reset strobe follows a start strobe by one cycle
  assert_reset_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |-> $past(start_pulse));

  // R8: the reset strobe is one cycle wide
  assert_reset_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |=> !bus_reset_pulse);
endmodule

// File: tb/twi_cond_frontend_test.sv
module twi_cond_frontend_test;
  localparam int FILT = 5;   // 50 MHz, 100 ns
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic scl_level, sda_level, start_pulse, stop_pulse;
  logic scl_rise_pulse, scl_fall_pulse, bus_reset_pulse;

  always #10 clk = ~clk;

  twi_cond_frontend #(
    .SYS_CLK_HZ  (50_000_000),
    .SUPPRESS_NS (100),
    .SYNC_STAGES (2),
    .RST_PULSES  (9)
  ) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_in          (scl),
    .sda_in          (sda),
    .scl_level       (scl_level),
    .sda_level       (sda_level),
    .start_pulse     (start_pulse),
    .stop_pulse      (stop_pulse),
    .scl_rise_pulse  (scl_rise_pulse),
    .scl_fall_pulse  (scl_fall_pulse),
    .bus_reset_pulse (bus_reset_pulse)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;
  int n_rst = 0, n_rst_wide = 0, n_rst_late = 0;
  logic prev_rst = 1'b0, prev_start = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_pulse)    n_start++;
      if (stop_pulse)     n_stop++;
      if (scl_rise_pulse) n_rise++;
      if (scl_fall_pulse) n_fall++;
      if (bus_reset_pulse) begin
        n_rst++;
        if (prev_rst)    n_rst_wide++;
        if (!prev_start) n_rst_late++;
      end
    end
    prev_rst   = bus_reset_pulse;
    prev_start = start_pulse;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hold(bit s, bit d, int n);
    @(negedge clk);
    scl = s;
    sda = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    check(scl_level == 1'b1, "R7", "scl_level after reset", scl_level, 1);
    check(sda_level == 1'b1, "R7", "sda_level after reset", sda_level, 1);
    check(start_pulse == 1'b0 && stop_pulse == 1'b0, "R7", "condition strobes", start_pulse | stop_pulse, 0);
    check(scl_rise_pulse == 1'b0 && scl_fall_pulse == 1'b0, "R7", "edge strobes", scl_rise_pulse | scl_fall_pulse, 0);
    check(bus_reset_pulse == 1'b0, "R7", "reset strobe", bus_reset_pulse, 0);
    repeat (HOLD) @(negedge clk);
    check(n_start + n_stop + n_rise + n_fall + n_rst == 0, "R7", "strobes while idle",
          n_start + n_stop + n_rise + n_fall + n_rst, 0);
  endtask

  task automatic t_latency;
    int lat = 0;
    int s0 = n_stop;
    @(negedge clk);
    sda = 1'b0;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (start_pulse && lat == 0) lat = n;
    end
    check(lat == FILT + 3, "R6", "start latency in clocks", lat, FILT + 3);
    hold(1, 1, HOLD);
    check(n_stop - s0 == 1, "R2", "stop after latency test", n_stop - s0, 1);
  endtask

  task automatic t_start_stop;
    int s0 = n_start, p0 = n_stop, r0 = n_rise, f0 = n_fall;
    hold(1, 0, HOLD);
    hold(0, 0, HOLD);
    hold(1, 0, HOLD);
    hold(1, 1, HOLD);
    check(n_start - s0 == 1, "R1", "start count", n_start - s0, 1);
    check(n_stop - p0 == 1, "R2", "stop count", n_stop - p0, 1);
    check(n_rise - r0 == 1, "R4", "rise count", n_rise - r0, 1);
    check(n_fall - f0 == 1, "R4", "fall count", n_fall - f0, 1);
  endtask

  task automatic t_data_under_low_clock;
    int s0 = n_start, p0 = n_stop, r0 = n_rise, f0 = n_fall;
    hold(0, 1, HOLD);
    hold(0, 0, HOLD);
    hold(0, 1, HOLD);
    hold(0, 0, HOLD);
    hold(1, 0, HOLD);
    hold(0, 0, HOLD);
    hold(0, 1, HOLD);
    hold(1, 1, HOLD);
    check(n_start - s0 == 0, "R3", "start with data under low clock", n_start - s0, 0);
    check(n_stop - p0 == 0, "R3", "stop with data under low clock", n_stop - p0, 0);
    check(n_rise - r0 == 2, "R4", "rise count over data bits", n_rise - r0, 2);
    check(n_fall - f0 == 2, "R4", "fall count over data bits", n_fall - f0, 2);
    check(sda_level == 1'b1 && scl_level == 1'b1, "R3", "levels back at idle", {scl_level, sda_level}, 3);
  endtask

  task automatic t_glitch;
    int s0 = n_start, r0 = n_rise, f0 = n_fall;
    hold(0, 1, FILT - 1);
    hold(1, 1, HOLD);
    check(n_fall - f0 == 0, "R5", "short SCL glitch fall", n_fall - f0, 0);
    check(n_rise - r0 == 0, "R5", "short SCL glitch rise", n_rise - r0, 0);
    hold(1, 0, FILT - 1);
    hold(1, 1, HOLD);
    check(n_start - s0 == 0, "R5", "short SDA glitch start", n_start - s0, 0);
    hold(0, 1, FILT);
    hold(1, 1, HOLD);
    check(n_fall - f0 == 1, "R5", "full-length SCL low fall", n_fall - f0, 1);
    check(n_rise - r0 == 1, "R5", "full-length SCL low rise", n_rise - r0, 1);
  endtask

  // pulses: SCL pulse count; low_at: pulse with SDA low (0 = none);
  // stop_first: stop before the second start
  task automatic send_pattern(int pulses, int low_at, bit stop_first);
    hold(1, 0, HOLD);
    hold(0, 0, HOLD);
    hold(0, 1, HOLD);
    for (int i = 1; i <= pulses; i++) begin
      bit d;
      d = (i == low_at) ? 1'b0 : 1'b1;
      if (!d) hold(0, 0, HOLD);
      hold(1, d, HOLD);
      hold(0, 1, HOLD);
    end
    if (stop_first) begin
      hold(0, 0, HOLD);
      hold(1, 0, HOLD);
      hold(1, 1, HOLD);
    end else begin
      hold(1, 1, HOLD);
    end
    hold(1, 0, HOLD);
    hold(0, 0, HOLD);
    hold(1, 0, HOLD);
    hold(1, 1, HOLD);
  endtask

  task automatic t_soft_reset;
    int r0 = n_rst, w0 = n_rst_wide, l0 = n_rst_late;
    send_pattern(9, 0, 1'b0);
    check(n_rst - r0 == 1, "R8", "reset strobes for valid pattern", n_rst - r0, 1);
    check(n_rst_wide - w0 == 0, "R8", "reset strobe wider than one cycle", n_rst_wide - w0, 0);
    check(n_rst_late - l0 == 0, "R8", "reset strobe not right after start", n_rst_late - l0, 0);
  endtask

  task automatic t_abandon;
    int r0;
    r0 = n_rst;
    send_pattern(9, 5, 1'b0);
    check(n_rst - r0 == 0, "R9", "SDA low at fifth pulse", n_rst - r0, 0);
    r0 = n_rst;
    send_pattern(9, 0, 1'b1);
    check(n_rst - r0 == 0, "R9", "stop before second start", n_rst - r0, 0);
    r0 = n_rst;
    send_pattern(8, 0, 1'b0);
    check(n_rst - r0 == 0, "R10", "eight pulses", n_rst - r0, 0);
    r0 = n_rst;
    send_pattern(10, 0, 1'b0);
    check(n_rst - r0 == 0, "R10", "ten pulses", n_rst - r0, 0);
    r0 = n_rst;
    send_pattern(9, 0, 1'b0);
    check(n_rst - r0 == 1, "R8", "valid pattern after abandoned ones", n_rst - r0, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_latency();
    t_start_stop();
    t_data_under_low_clock();
    t_glitch();
    t_soft_reset();
    t_abandon();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule